// File: doc/BRIEF.md
# Termination Probe Pulse Scheduler

This block times the short probe pulse that a display output switch places on its blue video line to find out whether a monitor termination is attached to each output port. While automatic port selection is active and the device is enabled, the scheduler issues a probe on a long idle period. It also issues one right after every vertical sync pulse ends, so that the probe falls in the back porch before active video starts.

Each probe is a strobe of a fixed, bounded number of clock cycles. On the final cycle of each probe the per-port comparator outputs are sampled. A port's presence flag follows the comparator only when two consecutive probes give the same answer. Triggers that arrive while a probe is running are dropped, not queued. A probe started by vertical sync restarts the idle period. The analog pulse level and the comparators themselves sit outside this block.

Top module: `probe_sched`

## Requirements
- R1: After reset `probe_o` is 0 and every bit of `present_o` is 0.
- R2: While `auto_en_i` is 0 no probe is issued, and a probe in progress when `auto_en_i` is seen low at a clock edge ends at that edge.
- R3: With no vertical sync activity, a probe starts PERIOD_CYC = CLK_KHZ*PERIOD_MS clock cycles after the first clock edge that sees `auto_en_i` high. Later idle probes start every PERIOD_CYC cycles, counted from one probe start to the next.
- R4: Each completed probe holds `probe_o` high for exactly WIDTH_CYC = CLK_KHZ*WIDTH_US/1000 consecutive cycles. WIDTH_US defaults to 20, below the 30 us limit.
- R5: The trailing edge of a vertical sync pulse starts a probe. With `vs_pol_i`=1 the pulse is high and its trailing edge is a fall; with `vs_pol_i`=0 the pulse is low and its trailing edge is a rise. `probe_o` rises at the third rising clock edge after the transition on `vsync_i`, through two synchronizer stages. A leading edge starts no probe.
- R6: A probe started by vertical sync restarts the idle period, so the next idle probe starts PERIOD_CYC cycles after that probe's start.
- R7: A trigger of either kind that arrives while a probe is high is ignored. The running probe keeps its width, no probe follows it at once, and the idle period is not restarted.
- R8: `cmp_i[i]` is sampled in the last cycle of each probe, where 1 means termination is seen. `present_o[i]` takes the sampled value at the clock edge that ends the probe, and only if the previous probe's sample for that port had the same value. Otherwise it holds.
- R9: When `auto_en_i` is low, all presence flags and the stored sample history are cleared. The first probe after re-enabling therefore never changes `present_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| auto_en_i | input | 1 | Automatic mode active and device enabled |
| vsync_i | input | 1 | Vertical sync, asynchronous to the clock |
| vs_pol_i | input | 1 | Vertical sync polarity: 1 = active high, 0 = active low |
| cmp_i | input | NUM_PORTS | Termination comparator result per port |
| probe_o | output | 1 | Probe drive strobe |
| present_o | output | NUM_PORTS | Filtered monitor presence per port |

## Verification
The idle timer is run alone, both after a fresh enable and after a vertical-sync probe. This separates an off-by-one in the period from a missing restart. Vertical sync pulses are sent in both polarities, with their leading edges held long enough to show that only the trailing edge fires. One edge is timed to land inside a running probe, which separates dropping a trigger from queueing it or restarting on it. Comparator values are driven to their real value only in the final probe cycle, with the inverse before that. Random sequences of repeated and changing values, together with a mid-probe disable, then show whether sampling happens at the right cycle and whether the filter requires two agreeing samples.

// File: rtl/probe_sched_pkg.sv
package probe_sched_pkg;
  typedef enum logic {
    VS_ACT_LOW  = 1'b0,
    VS_ACT_HIGH = 1'b1
  } vs_pol_e;

  // counter width able to hold values 0..n
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/vs_trail_det.sv
module vs_trail_det
  import probe_sched_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vsync_i,
  input  logic vs_pol_i,
  output logic trail_o
);
  logic [SYNC_STAGES:0] chain_q;
  logic act_new, act_old;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[SYNC_STAGES-1:0], vsync_i};
  end

  // normalise to "pulse active" level
  assign act_new = (vs_pol_i == VS_ACT_HIGH) ? chain_q[SYNC_STAGES-1] : ~chain_q[SYNC_STAGES-1];
  assign act_old = (vs_pol_i == VS_ACT_HIGH) ? chain_q[SYNC_STAGES]   : ~chain_q[SYNC_STAGES];
  assign trail_o = act_old & ~act_new;
endmodule

// File: rtl/idle_timer.sv
module idle_timer
  import probe_sched_pkg::*;
#(
  parameter int PERIOD_CYC = 1600000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int CNT_W = cnt_width(PERIOD_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic             en_q;

  assign tick_o = en_i & en_q & (cnt_q == CNT_W'(PERIOD_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      en_q <= en_i;
      // first enabled edge counts as a restart
      if (!en_i || !en_q || restart_i || tick_o) cnt_q <= '0;
      else                                       cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/probe_pulse.sv
module probe_pulse
  import probe_sched_pkg::*;
#(
  parameter int WIDTH_CYC = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic trig_i,
  output logic start_o,
  output logic busy_o,
  output logic last_o
);
  localparam int W_W = cnt_width(WIDTH_CYC);

  logic [W_W-1:0] wcnt_q;
  logic           busy_q;

  assign start_o = en_i & trig_i & ~busy_q;
  assign last_o  = busy_q & (wcnt_q == W_W'(WIDTH_CYC - 1));
  assign busy_o  = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      wcnt_q <= '0;
    end else if (!en_i) begin
      busy_q <= 1'b0;
      wcnt_q <= '0;
    end else if (start_o) begin
      busy_q <= 1'b1;
      wcnt_q <= '0;
    end else if (last_o) begin
      busy_q <= 1'b0;
      wcnt_q <= '0;
    end else if (busy_q) begin
      wcnt_q <= wcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/presence_filter.sv
module presence_filter #(
  parameter int NUM_PORTS = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 sample_i,
  input  logic [NUM_PORTS-1:0] cmp_i,
  output logic [NUM_PORTS-1:0] present_o
);
  logic have_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       have_q <= 1'b0;
    else if (!en_i)    have_q <= 1'b0;
    else if (sample_i) have_q <= 1'b1;
  end

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    logic prev_q, pres_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        pres_q <= 1'b0;
      end else if (!en_i) begin
        prev_q <= 1'b0;
        pres_q <= 1'b0;
      end else if (sample_i) begin
        prev_q <= cmp_i[g];
        if (have_q && (prev_q == cmp_i[g])) pres_q <= cmp_i[g];
      end
    end
    assign present_o[g] = pres_q;
  end
endmodule

// File: rtl/probe_sched.sv
module probe_sched #(
  parameter int CLK_KHZ     = 1000,
  parameter int PERIOD_MS   = 1600,
  parameter int WIDTH_US    = 20,
  parameter int NUM_PORTS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 auto_en_i,
  input  logic                 vsync_i,
  input  logic                 vs_pol_i,
  input  logic [NUM_PORTS-1:0] cmp_i,
  output logic                 probe_o,
  output logic [NUM_PORTS-1:0] present_o
);
  localparam int PERIOD_CYC = CLK_KHZ * PERIOD_MS;
  localparam int WIDTH_RAW  = (CLK_KHZ * WIDTH_US) / 1000;
  localparam int WIDTH_CYC  = (WIDTH_RAW < 1) ? 1 : WIDTH_RAW;

  logic vs_trail, idle_tick, start, last;

  vs_trail_det #(.SYNC_STAGES(SYNC_STAGES)) i_vs_det (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vsync_i  (vsync_i),
    .vs_pol_i (vs_pol_i),
    .trail_o  (vs_trail)
  );

  idle_timer #(.PERIOD_CYC(PERIOD_CYC)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (auto_en_i),
    .restart_i (start & vs_trail),
    .tick_o    (idle_tick)
  );

  probe_pulse #(.WIDTH_CYC(WIDTH_CYC)) i_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (auto_en_i),
    .trig_i  (vs_trail | idle_tick),
    .start_o (start),
    .busy_o  (probe_o),
    .last_o  (last)
  );

  presence_filter #(.NUM_PORTS(NUM_PORTS)) i_filter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (auto_en_i),
    .sample_i  (last),
    .cmp_i     (cmp_i),
    .present_o (present_o)
  );
endmodule

// File: rtl/probe_sched_chk.sv
module probe_sched_chk #(
  parameter int WIDTH_CYC = 20,
  parameter int NUM_PORTS = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 auto_en_i,
  input logic                 probe_o,
  input logic [NUM_PORTS-1:0] present_o
);
  localparam int HW = $clog2(WIDTH_CYC + 2);

  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hi_cnt <= '0;
    else if (probe_o) hi_cnt <= hi_cnt + 1'b1;
    else              hi_cnt <= '0;
  end

  AST_NO_PROBE_DIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_en_i |=> !probe_o); // R2

  AST_WIDTH_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    probe_o |-> (hi_cnt < HW'(WIDTH_CYC))); // R4

  AST_WIDTH_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(probe_o) && $past(auto_en_i)) |-> (hi_cnt == HW'(WIDTH_CYC))); // R4

  AST_PRES_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (present_o != $past(present_o)) |-> ($fell(probe_o) || !$past(auto_en_i))); // R8

  AST_PRES_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_en_i |=> (present_o == '0)); // R9
endmodule

bind probe_sched probe_sched_chk #(
  .WIDTH_CYC (WIDTH_CYC),
  .NUM_PORTS (NUM_PORTS)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .auto_en_i (auto_en_i),
  .probe_o   (probe_o),
  .present_o (present_o)
);

// File: tb/test_probe_sched.sv
`timescale 1ns/1ps
module test_probe_sched;
  localparam int P = 1000;  // CLK_KHZ*PERIOD_MS
  localparam int W = 6;     // CLK_KHZ*WIDTH_US/1000

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       auto_en_i = 1'b0;
  logic       vsync_i = 1'b0;
  logic       vs_pol_i = 1'b1;
  logic [1:0] cmp_i = 2'b00;
  logic       probe_o;
  logic [1:0] present_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic       m_have = 1'b0;
  logic [1:0] m_prev = 2'b00, m_pres = 2'b00;

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  probe_sched #(.CLK_KHZ(1000), .PERIOD_MS(1), .WIDTH_US(6), .NUM_PORTS(2)) i_probe_sched (
    .clk_i(clk_i), .rst_ni(rst_ni), .auto_en_i(auto_en_i), .vsync_i(vsync_i),
    .vs_pol_i(vs_pol_i), .cmp_i(cmp_i), .probe_o(probe_o), .present_o(present_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] model_pres(input logic have, input logic [1:0] prev,
                                             input logic [1:0] pres, input logic [1:0] v);
    logic [1:0] agree;
    agree = have ? ~(v ^ prev) : 2'b00;
    return (pres & ~agree) | (v & agree);
  endfunction

  task automatic wait_rise(input int max, output int t);
    t = -1;
    for (int i = 0; i < max; i++) begin
      @(negedge clk_i);
      if (probe_o) begin t = cyc; break; end
    end
  endtask

  task automatic idle_low(input string req, input int n);
    int hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      if (probe_o) hi++;
    end
    chk(req, hi, 0);
  endtask

  // called at the negedge where the probe is first seen high
  task automatic probe_sample(input logic [1:0] v);
    int hi = 1;
    cmp_i = ~v;
    for (int i = 1; i < W; i++) begin
      @(negedge clk_i);
      if (probe_o) hi++;
    end
    cmp_i = v;  // last probe cycle
    @(negedge clk_i);
    chk("R4 width", hi, W);
    chk("R4 end", int'(probe_o), 0);
    m_pres = model_pres(m_have, m_prev, m_pres, v);
    m_prev = v;
    m_have = 1'b1;
    chk("R8 presence", int'(present_o), int'(m_pres));
  endtask

  initial begin
    int t, s, c, e;
    void'($urandom(32'h5eed_0042));
    #55;
    chk("R1 probe", int'(probe_o), 0);
    chk("R1 present", int'(present_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    idle_low("R2 disabled", (5 * P) / 2);

    auto_en_i = 1'b1;
    e = cyc + 1;
    wait_rise(P + 10, t);
    chk("R3 first", t, e + P);
    probe_sample(2'b01);
    chk("R8 single sample", int'(present_o), 0);
    s = t;
    wait_rise(P + 10, t);
    chk("R3 period", t, s + P);
    probe_sample(2'b01);
    chk("R8 agree", int'(present_o), 1);

    // active-high vsync
    vsync_i = 1'b1;
    idle_low("R5 leading high", 8);
    vsync_i = 1'b0;
    c = cyc;
    wait_rise(10, t);
    chk("R5 trail fall", t, c + 3);
    probe_sample(2'b11);
    s = t;
    wait_rise(P + 10, t);
    chk("R6 restart", t, s + P);
    probe_sample(2'b11);
    s = t;

    // switch to active-low vsync
    vsync_i = 1'b1;
    idle_low("R5 polarity set", 5);
    vs_pol_i = 1'b0;
    idle_low("R5 polarity change", 5);
    vsync_i = 1'b0;
    idle_low("R5 leading low", 6);
    vsync_i = 1'b1;
    c = cyc;
    wait_rise(10, t);
    chk("R5 trail rise", t, c + 3);
    probe_sample(2'b10);
    s = t;

    // trigger inside a running probe
    vsync_i = 1'b0;
    wait_rise(P + 10, t);
    chk("R6 idle after vsync", t, s + P);
    vsync_i = 1'b1;
    probe_sample(2'b10);
    s = t;
    wait_rise(P + 10, t);
    chk("R7 ignored trigger", t, s + P);

    // disable mid-probe
    auto_en_i = 1'b0;
    @(negedge clk_i);
    chk("R2 abort", int'(probe_o), 0);
    chk("R9 clear", int'(present_o), 0);
    m_have = 1'b0; m_prev = 2'b00; m_pres = 2'b00;
    idle_low("R2 off", 50);
    auto_en_i = 1'b1;
    e = cyc + 1;
    wait_rise(P + 10, t);
    chk("R3 re-enable", t, e + P);
    probe_sample(2'b10);
    chk("R9 first after enable", int'(present_o), 0);
    s = t;

    // random mix
    for (int k = 0; k < 30; k++) begin
      logic [1:0] v;
      v = ($urandom_range(0, 1) == 0) ? m_prev : 2'($urandom_range(0, 3));
      if ($urandom_range(0, 2) == 0) begin
        wait_rise(P + 10, t);
        chk("R3 random idle", t, s + P);
      end else begin
        repeat ($urandom_range(20, 600)) @(negedge clk_i);
        vsync_i = 1'b0;
        repeat ($urandom_range(2, 20)) @(negedge clk_i);
        vsync_i = 1'b1;
        c = cyc;
        wait_rise(10, t);
        chk("R5 random vsync", t, c + 3);
      end
      probe_sample(v);
      s = t;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(150000 * 20);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule